// File: doc/BRIEF.md
# Streaming Systolic Reducer (Distinct / Monomial Merge)

This block takes in a finite sequence of fixed-width words, one per clock, and returns the same sequence reduced. Which reduction it performs is fixed by a parameter when the block is built. In distinct mode every repeated word is removed, so each value is emitted exactly once. In monomial-merge mode each word is a monomial over a prime field. Words with the same exponent vector are combined into one term whose coefficient is the sum of their coefficients modulo `P`. A term whose summed coefficient is zero is never emitted.

Each cell of a linear chain holds one stored word and one travelling word. A word moving down the chain settles in the first empty cell it reaches. If it matches a stored word it is absorbed. Otherwise it moves on.

A word that leaves the last cell is parked in an overflow queue. Once a pass has drained, every stored word is final. The stored words are emitted and the array is cleared. The parked words are then fed through again as a new pass. This repeats until no words are parked, and the number of passes is at most ceil(n / `DEPTH`).

Both streams use valid/ready handshakes. An input word is taken on a clock edge where `in_valid` and `in_ready` are both high. An output word is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the output word is held unchanged. `in_ready` is high only while a sequence is being loaded. It is also dropped when the parked words plus the words in flight would fill the overflow queue. A sequence therefore holds at most `DEPTH + FIFO_DEPTH` words. A one-cycle `done` pulse marks the end of each reduced sequence.

Top module: `sysred_top`

## Requirements
- R1: After reset, `in_ready` is 1 and both `out_valid` and `done` are 0.
- R2: In distinct mode, the output multiset equals the set of distinct input words: each value appears once, in any order.
- R3: In monomial-merge mode, one term is emitted for each exponent vector seen. Its coefficient equals the sum of the input coefficients for that vector, reduced modulo `P`.
- R4: In monomial-merge mode, no emitted term has a zero coefficient. This holds whether the zero comes from cancellation or from a zero input.
- R5: Sequences longer than `DEPTH` are reduced correctly through repeated passes of the overflow queue, with the same results as R2 and R3.
- R6: From the edge that accepts the word flagged `in_last` until the `done` pulse, `in_ready` stays 0.
- R7: While `out_valid` is 1 and `out_ready` is 0, on the next cycle `out_valid` is still 1 and `out_data` is unchanged.
- R8: `done` is high for exactly one cycle, and only after the last output word. On the cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R9: The overflow queue never takes a word while full. A sequence of `DEPTH + FIFO_DEPTH` all-different words is accepted and reduced without loss.
- R10: Word layout: the coefficient occupies the top `FW` bits, and exponent k occupies bits [k*FW +: FW]. Here `FW` = ceil(log2 `P`) and each field holds 0 to `P`-1. Distinct mode compares the whole word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts an input word this cycle |
| in_data | input | W | Input word (layout per R10) |
| in_last | input | 1 | Marks the final word of a sequence |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | W | Reduced output word |
| done | output | 1 | One-cycle pulse after the last output word |

## Verification
Four properties are checked on every cycle:
- the output word and valid are held while `out_ready` is low;
- `in_ready` is closed after the last word is accepted;
- `done` is a lone pulse with no output beside it;
- the overflow queue is never pushed while full or popped while empty, and no emitted term carries a zero coefficient.

The bench's scenarios are the only evidence for the reductions themselves. These are that every distinct value or exponent vector appears exactly once with the correct modular sum, and that multi-pass runs give the same result as single-pass runs. The scenarios are compared against a reference map built from the same stream. They use short and long sequences, cancelling coefficients, a full-capacity sequence of all-different words, and random output back-pressure.

// File: rtl/sysred_pkg.sv
package sysred_pkg;
  typedef enum logic {
    MODE_DISTINCT = 1'b0,
    MODE_POLYADD  = 1'b1
  } sr_mode_e;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_FLUSH,
    ST_EMIT,
    ST_REFEED,
    ST_DONE
  } sr_state_e;
endpackage

// File: rtl/sysred_cell.sv
module sysred_cell
  import sysred_pkg::*;
#(
  parameter sr_mode_e MODE = MODE_POLYADD,
  parameter int FW   = 3,
  parameter int NVAR = 2,
  parameter int P    = 5,
  localparam int W   = FW * (NVAR + 1),
  localparam int EW  = FW * NVAR
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         clr,
  input  logic         up_v,
  input  logic [W-1:0] up_d,
  output logic         st_v,
  output logic [W-1:0] st_d,
  output logic         dn_v,
  output logic [W-1:0] dn_d
);
  logic         hit;
  logic [W-1:0] merged;

  generate
    if (MODE == MODE_POLYADD) begin : g_poly
      localparam logic [FW:0] PMOD = (FW + 1)'(P);
      logic [FW:0]   sum_w;
      logic [FW-1:0] sum_m;
      always_comb begin
        sum_w = {1'b0, st_d[W-1 -: FW]} + {1'b0, up_d[W-1 -: FW]};
        if (sum_w >= PMOD) sum_m = FW'(sum_w - PMOD);
        else               sum_m = sum_w[FW-1:0];
      end
      // exponent vectors compared, coefficient ignored
      assign hit    = st_v && up_v && (st_d[EW-1:0] == up_d[EW-1:0]);
      assign merged = {sum_m, st_d[EW-1:0]};
    end else begin : g_dist
      assign hit    = st_v && up_v && (st_d == up_d);
      assign merged = st_d;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_v <= 1'b0;
      st_d <= '0;
      dn_v <= 1'b0;
      dn_d <= '0;
    end else begin
      if (clr) st_v <= 1'b0;
      if (adv) begin
        if (up_v && !st_v) begin
          st_v <= 1'b1;
          st_d <= up_d;
          dn_v <= 1'b0;
        end else if (hit) begin
          st_d <= merged;
          dn_v <= 1'b0;
        end else begin
          dn_v <= up_v;
          dn_d <= up_d;
        end
      end
    end
  end
endmodule

// File: rtl/sysred_fifo.sv
module sysred_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_d,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_d;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sysred_ctrl.sv
module sysred_ctrl
  import sysred_pkg::*;
#(
  parameter int DEPTH      = 4,
  parameter int FIFO_DEPTH = 16,
  localparam int IW  = $clog2(DEPTH + 1),
  localparam int CW  = $clog2(FIFO_DEPTH + 1),
  localparam int EXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic           in_last,
  input  logic [IW-1:0]  inflight,
  input  logic [CW-1:0]  fifo_cnt,
  input  logic           pv_any,
  input  logic           emit_ok,
  input  logic           out_ready,
  output logic           in_ready,
  output logic           adv,
  output logic           refeed,
  output logic           out_valid,
  output logic           cell_clr,
  output logic           done,
  output logic [EXW-1:0] emit_idx
);
  sr_state_e     state;
  logic [CW-1:0] left;

  always_comb begin
    in_ready  = (state == ST_LOAD) && ((int'(fifo_cnt) + int'(inflight)) < FIFO_DEPTH);
    adv       = (state == ST_LOAD) || (state == ST_FLUSH) || (state == ST_REFEED);
    refeed    = (state == ST_REFEED);
    out_valid = (state == ST_EMIT) && emit_ok;
    cell_clr  = (state == ST_EMIT) && (!emit_ok || out_ready);
    done      = (state == ST_DONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_LOAD;
      emit_idx <= '0;
      left     <= '0;
    end else begin
      case (state)
        ST_LOAD:
          if (in_valid && in_ready && in_last) state <= ST_FLUSH;
        ST_FLUSH:
          if (!pv_any) begin
            state    <= ST_EMIT;
            emit_idx <= '0;
          end
        ST_EMIT:
          if (cell_clr) begin
            if (emit_idx == EXW'(DEPTH - 1)) begin
              if (fifo_cnt == '0) state <= ST_DONE;
              else begin
                state <= ST_REFEED;
                left  <= fifo_cnt;
              end
            end else begin
              emit_idx <= emit_idx + 1'b1;
            end
          end
        ST_REFEED: begin
          left <= left - 1'b1;
          if (left == CW'(1)) state <= ST_FLUSH;
        end
        default: state <= ST_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/sysred_top.sv
module sysred_top
  import sysred_pkg::*;
#(
  parameter sr_mode_e MODE = MODE_POLYADD,
  parameter int NVAR       = 2,
  parameter int P          = 5,
  parameter int DEPTH      = 4,
  parameter int FIFO_DEPTH = 16,
  localparam int FW  = $clog2(P),
  localparam int W   = FW * (NVAR + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         done
);
  localparam int IW  = $clog2(DEPTH + 1);
  localparam int CW  = $clog2(FIFO_DEPTH + 1);
  localparam int EXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] st_v, pv_v, clr_v;
  logic [W-1:0]     st_d [DEPTH];
  logic [W-1:0]     pv_d [DEPTH];

  logic           src_v;
  logic [W-1:0]   src_d;
  logic           adv, refeed, cell_clr, emit_ok, pv_any;
  logic [EXW-1:0] emit_idx;
  logic [IW-1:0]  inflight;
  logic           fifo_push, fifo_pop;
  logic [W-1:0]   fifo_head;
  logic [CW-1:0]  fifo_cnt;

  assign src_v     = refeed ? 1'b1 : (in_valid && in_ready);
  assign src_d     = refeed ? fifo_head : in_data;
  assign pv_any    = |pv_v;
  assign inflight  = IW'($countones(pv_v));
  assign fifo_push = adv && pv_v[DEPTH-1];
  assign fifo_pop  = refeed;
  assign out_data  = st_d[emit_idx];

  generate
    if (MODE == MODE_POLYADD) begin : g_emit_poly
      assign emit_ok = st_v[emit_idx] && (st_d[emit_idx][W-1 -: FW] != '0);
    end else begin : g_emit_dist
      assign emit_ok = st_v[emit_idx];
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic         up_v;
      logic [W-1:0] up_d;
      if (i == 0) begin : g_head
        assign up_v = src_v;
        assign up_d = src_d;
      end else begin : g_link
        assign up_v = pv_v[i-1];
        assign up_d = pv_d[i-1];
      end
      assign clr_v[i] = cell_clr && (emit_idx == EXW'(i));

      sysred_cell #(.MODE(MODE), .FW(FW), .NVAR(NVAR), .P(P)) u_cell (
        .clk (clk),
        .rst_n (rst_n),
        .adv (adv),
        .clr (clr_v[i]),
        .up_v (up_v),
        .up_d (up_d),
        .st_v (st_v[i]),
        .st_d (st_d[i]),
        .dn_v (pv_v[i]),
        .dn_d (pv_d[i])
      );
    end
  endgenerate

  sysred_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_ovf (
    .clk (clk),
    .rst_n (rst_n),
    .push (fifo_push),
    .push_d (pv_d[DEPTH-1]),
    .pop (fifo_pop),
    .head (fifo_head),
    .count (fifo_cnt)
  );

  sysred_ctrl #(.DEPTH(DEPTH), .FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk (clk),
    .rst_n (rst_n),
    .in_valid (in_valid),
    .in_last (in_last),
    .inflight (inflight),
    .fifo_cnt (fifo_cnt),
    .pv_any (pv_any),
    .emit_ok (emit_ok),
    .out_ready (out_ready),
    .in_ready (in_ready),
    .adv (adv),
    .refeed (refeed),
    .out_valid (out_valid),
    .cell_clr (cell_clr),
    .done (done),
    .emit_idx (emit_idx)
  );
endmodule

// File: rtl/sysred_chk.sv
module sysred_chk
  import sysred_pkg::*;
#(
  parameter sr_mode_e MODE = MODE_POLYADD,
  parameter int FW         = 3,
  parameter int W          = 9,
  parameter int FIFO_DEPTH = 16,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_data,
  input logic          done,
  input logic          fifo_push,
  input logic          fifo_pop,
  input logic [CW-1:0] fifo_cnt
);
  p_closed_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !out_valid && in_ready));

  p_done_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_push && !fifo_pop) |-> (int'(fifo_cnt) < FIFO_DEPTH));

  p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_cnt != '0));

  generate
    if (MODE == MODE_POLYADD) begin : g_poly
      p_nonzero_coef_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data[W-1 -: FW] != '0));
    end
  endgenerate
endmodule

bind sysred_top sysred_chk #(.MODE(MODE), .FW(FW), .W(W), .FIFO_DEPTH(FIFO_DEPTH)) u_sysred_chk (
  .clk (clk),
  .rst_n (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_last (in_last),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data (out_data),
  .done (done),
  .fifo_push (fifo_push),
  .fifo_pop (fifo_pop),
  .fifo_cnt (fifo_cnt)
);

// File: tb/test_sysred_top.sv
module test_sysred_top;
  import sysred_pkg::*;

  localparam int NVAR = 2, P = 5, DEPTH = 4, FIFO_DEPTH = 16;
  localparam int FW = 3, W = 9, EW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n = 1'b0, sel = 1'b1, in_valid = 1'b0, in_last = 1'b0;
  logic         out_ready = 1'b1, bp_on = 1'b0, busy = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         rdy_p, ov_p, dn_p, rdy_d, ov_d, dn_d;
  logic [W-1:0] od_p, od_d;

  sysred_top #(.MODE(MODE_POLYADD), .NVAR(NVAR), .P(P), .DEPTH(DEPTH), .FIFO_DEPTH(FIFO_DEPTH)) i_sysred_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid && sel), .in_ready(rdy_p), .in_data(in_data),
    .in_last(in_last), .out_valid(ov_p), .out_ready(out_ready), .out_data(od_p), .done(dn_p));

  sysred_top #(.MODE(MODE_DISTINCT), .NVAR(NVAR), .P(P), .DEPTH(DEPTH), .FIFO_DEPTH(FIFO_DEPTH)) i_sysred_top_dist (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid && !sel), .in_ready(rdy_d), .in_data(in_data),
    .in_last(in_last), .out_valid(ov_d), .out_ready(out_ready), .out_data(od_d), .done(dn_d));

  wire         in_ready  = sel ? rdy_p : rdy_d;
  wire         out_valid = sel ? ov_p : ov_d;
  wire [W-1:0] out_data  = sel ? od_p : od_d;
  wire         done      = sel ? dn_p : dn_d;

  int checks = 0, errors = 0, cyc = 0, done_cnt = 0;
  logic [W-1:0] got[$];
  logic         hold_pend = 1'b0, prev_done = 1'b0;
  logic [W-1:0] hold_d = '0;

  function automatic logic [W-1:0] mk(input int c, input int e1, input int e0);
    return {FW'(c), FW'(e1), FW'(e0)};
  endfunction

  // per-cycle monitor: collects output, checks handshake rules
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired: actual cycle %0d expected < 150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    if (rst_n) begin
      if (hold_pend) begin
        checks++;
        if (!out_valid || out_data !== hold_d) begin
          errors++;
          $display("FAIL R7 hold: actual valid=%0b data=%h expected valid=1 data=%h", out_valid, out_data, hold_d);
        end
      end
      if (prev_done) begin
        checks++;
        if (done || out_valid || !in_ready) begin
          errors++;
          $display("FAIL R8 after done: actual done=%0b ov=%0b rdy=%0b expected 0 0 1", done, out_valid, in_ready);
        end
      end
      if (busy && !done) begin
        checks++;
        if (in_ready) begin
          errors++;
          $display("FAIL R6 in_ready while reducing: actual 1 expected 0");
        end
      end
      out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
      if (out_valid && out_ready) got.push_back(out_data);
      hold_pend = out_valid && !out_ready;
      hold_d    = out_data;
      prev_done = done;
      if (done) begin
        done_cnt++;
        busy = 1'b0;
      end
    end
  end

  task automatic send(input logic [W-1:0] q[$]);
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = q[i];
      in_last  = (i == q.size() - 1);
      while (!in_ready) @(negedge clk);
    end
    @(posedge clk);
    #1;
    busy     = 1'b1;
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run(input logic poly, input logic [W-1:0] q[$], input string tag);
    int exp_m[int];
    int seen[int];
    int prev, n, nexp;
    sel = poly;
    got.delete();
    foreach (q[i]) begin
      int k;
      if (poly) begin
        k = int'(q[i][EW-1:0]);
        if (!exp_m.exists(k)) exp_m[k] = 0;
        exp_m[k] = (exp_m[k] + int'(q[i][W-1 -: FW])) % P;
      end else begin
        k = int'(q[i]);
        exp_m[k] = 1;
      end
    end
    prev = done_cnt;
    send(q);
    n = 0;
    while (done_cnt == prev && n < 20000) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (done_cnt == prev) begin
      errors++;
      $display("FAIL %s no done pulse: actual none expected one", tag);
    end
    foreach (got[i]) begin
      int k, c;
      k = poly ? int'(got[i][EW-1:0]) : int'(got[i]);
      c = int'(got[i][W-1 -: FW]);
      checks++;
      if (poly && c == 0) begin
        errors++;
        $display("FAIL R4 %s zero coefficient out: actual %h expected nonzero", tag, got[i]);
      end else if (!exp_m.exists(k) || seen.exists(k) || (poly && exp_m[k] != c)) begin
        errors++;
        $display("FAIL %s unexpected word: actual %h expected coef %0d once", tag, got[i],
                 exp_m.exists(k) ? exp_m[k] : -1);
      end
      seen[k] = 1;
    end
    nexp = 0;
    foreach (exp_m[k]) if (!poly || exp_m[k] != 0) nexp++;
    checks++;
    if (nexp != got.size()) begin
      errors++;
      $display("FAIL %s output count: actual %0d expected %0d", tag, got.size(), nexp);
    end
  endtask

  initial begin
    logic [W-1:0] q[$];
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state of both instances
    checks++;
    if (!rdy_p || ov_p || dn_p || !rdy_d || ov_d || dn_d) begin
      errors++;
      $display("FAIL R1 reset: actual rdy=%0b%0b ov=%0b%0b done=%0b%0b expected 11 00 00",
               rdy_p, rdy_d, ov_p, ov_d, dn_p, dn_d);
    end
    // R2 short distinct with repeats
    q = '{9'h011, 9'h022, 9'h011, 9'h033, 9'h022};
    run(1'b0, q, "R2");
    // R3 R10 short polynomial by field layout
    q = '{mk(1,0,1), mk(2,1,0), mk(3,0,1), mk(4,2,2)};
    run(1'b1, q, "R3 R10");
    // R4 cancelling coefficients and zero input
    q = '{mk(2,1,1), mk(1,0,2), mk(3,1,1), mk(0,2,0)};
    run(1'b1, q, "R4");
    // R9 full-capacity all-different sequence, R5 multi-pass
    q.delete();
    for (int i = 0; i < DEPTH + FIFO_DEPTH; i++) q.push_back(W'(i * 7 + 3));
    run(1'b0, q, "R9 R5");
    // R5 R7 random long sequences with output back-pressure
    bp_on = 1'b1;
    for (int r = 0; r < 6; r++) begin
      q.delete();
      for (int i = 0; i < 8 + r * 2; i++) q.push_back(W'($urandom % 12));
      run(1'b0, q, "R5 R2 R7");
      q.delete();
      for (int i = 0; i < 8 + r * 2; i++)
        q.push_back(mk($urandom % P, $urandom % 3, $urandom % 3));
      run(1'b1, q, "R5 R3 R7");
    end
    bp_on = 1'b0;
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule